// File: doc/BRIEF.md
# Shared Dual-Port RAM Arbiter

This block lets four compute modules that run side by side share one on-chip RAM with two access ports. Each module drives an access request made of an enable, a write-enable, an address and write data, and receives read data back. In every cycle the arbiter picks up to two active requesters and gives each one a RAM port. Every active requester that is not picked gets a stall. A stall freezes the whole requesting module. That module keeps its request stable until a later cycle grants it.

Under contention the choice follows a rotating priority. A pointer names the requester with the highest priority. After each cycle in which something is granted, the pointer moves one place past the requester that was granted last in rotation order. Read data comes back one cycle after the grant, and only to the requester that was granted. A build-time mode swaps the arbiter for a plain OR-merge onto one RAM port. That mode keeps no arbitration state and is meant for modules that are known never to be active at the same time.

Top module: `shmem_arbiter`

## Requirements
- R1: After the synchronous active-high reset, all read-data outputs are zero, no stall is raised, and the rotation pointer is at requester 0. The first contended cycle therefore grants requesters 0 and 1 in that order.
- R2: At most two requesters are granted in any cycle. When two or fewer requesters are active, none of them is stalled.
- R3: Port 0 goes to the first active requester found in rotation order starting at the pointer, and port 1 goes to the next one. After a cycle with any grant, the pointer moves to one past the last granted requester (index modulo 4).
- R4: In the same cycle as the request, stall bit i is high exactly when requester i is active and not granted. An idle requester is never stalled.
- R5: A granted write (write-enable 1) stores its data at its address, and any requester can read that value back in a later cycle. A stalled write leaves memory unchanged until it is granted.
- R6: A granted read (write-enable 0) returns the stored word on that requester's read-data output in the next cycle. In every other case the read-data output is zero: after a write, after a stall, and after an idle cycle.
- R7: With four requesters, a requester that is stalled in one cycle and keeps its request is granted in the next cycle.
- R8: In the OR-merge build mode, stall is never raised. The single active requester's access goes straight to the RAM, and its read data returns one cycle later.
- R9: When both ports write the same address in one cycle, the port-1 requester's data is stored.
- R10: A read granted in the same cycle as a write to the same address, on the other port, returns the value stored before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_en_i | input | NREQ | Per-requester access enable for this cycle |
| req_we_i | input | NREQ | Per-requester write select: 1 write, 0 read |
| req_addr_i | input | NREQ*ADDR_W | Addresses, requester i in bits [i*ADDR_W +: ADDR_W] |
| req_wdata_i | input | NREQ*DATA_W | Write data, requester i in bits [i*DATA_W +: DATA_W] |
| req_rdata_o | output | NREQ*DATA_W | Read data, requester i in bits [i*DATA_W +: DATA_W] |
| req_stall_o | output | NREQ | Per-requester stall; the module freezes while it is high |

## Verification
Stall is a combinational function of the current requests and the registered pointer. The bench samples it 1 ns after it drives the inputs, in the same cycle and ahead of the next rising edge. Read data passes through one register, both in the RAM and in the return routing. The bench therefore checks it 1 ns after the following rising edge, against a value taken from its own memory model before that cycle's writes were applied. The pointer is never observed directly: its effect is checked through the stall pattern of later contended cycles, predicted by an independent rotation model.

// File: rtl/shmem_pkg.sv
package shmem_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    // build-time variant of the access combiner
    typedef enum logic {
        ARB_ROTATE = 1'b0,
        ARB_MERGE  = 1'b1
    } arb_mode_e;

    // per-requester record of where last cycle's read went
    typedef struct packed {
        logic hit;   // a read was granted last cycle
        logic port;  // RAM port that served it
    } route_t;

    // next index in a ring of n entries
    function automatic int wrap_inc(input int idx, input int n);
        return (idx + 1 >= n) ? 0 : idx + 1;
    endfunction
endpackage

// File: rtl/shmem_rr_pick.sv
module shmem_rr_pick #(
    parameter int N  = 4,
    parameter int PW = 2
) (
    input  logic [N-1:0]  req_i,
    input  logic [PW-1:0] ptr_i,
    output logic [N-1:0]  gnt_o,
    output logic [PW-1:0] idx_o,
    output logic          found_o
);
    timeunit 1ns;
    timeprecision 1ps;

    // first set bit of req_i scanning upward from ptr_i with wrap
    always_comb begin
        int slot;
        gnt_o   = '0;
        idx_o   = '0;
        found_o = 1'b0;
        slot    = 0;
        for (int k = 0; k < N; k++) begin
            slot = int'(ptr_i) + k;
            if (slot >= N) slot = slot - N;
            if (!found_o && req_i[slot]) begin
                found_o     = 1'b1;
                gnt_o[slot] = 1'b1;
                idx_o       = PW'(slot);
            end
        end
    end
endmodule

// File: rtl/shmem_port_mux.sv
module shmem_port_mux #(
    parameter int N  = 4,
    parameter int AW = 6,
    parameter int DW = 32
) (
    input  logic [N-1:0]    gnt_i,
    input  logic [N-1:0]    we_i,
    input  logic [N*AW-1:0] addr_i,
    input  logic [N*DW-1:0] wdata_i,
    output logic            en_o,
    output logic            we_o,
    output logic [AW-1:0]   addr_o,
    output logic [DW-1:0]   wdata_o
);
    timeunit 1ns;
    timeprecision 1ps;

    // AND-OR combine: with a one-hot or empty select this is a mux,
    // and in merge mode it is the plain OR of the quiet-zero requesters
    always_comb begin
        en_o    = |gnt_i;
        we_o    = 1'b0;
        addr_o  = '0;
        wdata_o = '0;
        for (int i = 0; i < N; i++) begin
            we_o    = we_o    | (we_i[i] & gnt_i[i]);
            addr_o  = addr_o  | (addr_i[i*AW +: AW]  & {AW{gnt_i[i]}});
            wdata_o = wdata_o | (wdata_i[i*DW +: DW] & {DW{gnt_i[i]}});
        end
    end
endmodule

// File: rtl/shmem_dpram.sv
module shmem_dpram #(
    parameter int AW = 6,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          a_en,
    input  logic          a_we,
    input  logic [AW-1:0] a_addr,
    input  logic [DW-1:0] a_wdata,
    output logic [DW-1:0] a_rdata,
    input  logic          b_en,
    input  logic          b_we,
    input  logic [AW-1:0] b_addr,
    input  logic [DW-1:0] b_wdata,
    output logic [DW-1:0] b_rdata
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] store [DEPTH];

    // port B is applied after port A, so B wins a same-address write;
    // reads see the contents from before this edge
    always_ff @(posedge clk) begin
        if (a_en) begin
            if (a_we) store[a_addr] <= a_wdata;
            else      a_rdata       <= store[a_addr];
        end
        if (b_en) begin
            if (b_we) store[b_addr] <= b_wdata;
            else      b_rdata       <= store[b_addr];
        end
    end
endmodule

// File: rtl/shmem_arbiter.sv
module shmem_arbiter
    import shmem_pkg::*;
#(
    parameter int        NREQ   = 4,
    parameter int        ADDR_W = 6,
    parameter int        DATA_W = 32,
    parameter arb_mode_e MODE   = ARB_ROTATE
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NREQ-1:0]          req_en_i,
    input  logic [NREQ-1:0]          req_we_i,
    input  logic [NREQ*ADDR_W-1:0]   req_addr_i,
    input  logic [NREQ*DATA_W-1:0]   req_wdata_i,
    output logic [NREQ*DATA_W-1:0]   req_rdata_o,
    output logic [NREQ-1:0]          req_stall_o
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int NPORT = 2;
    localparam int PW    = (NREQ > 1) ? $clog2(NREQ) : 1;

    logic [NREQ-1:0]   gnt      [NPORT];
    logic [NREQ-1:0]   served;
    logic [NPORT-1:0]  ram_en;
    logic [NPORT-1:0]  ram_we;
    logic [ADDR_W-1:0] ram_addr [NPORT];
    logic [DATA_W-1:0] ram_wd   [NPORT];
    logic [DATA_W-1:0] ram_rd   [NPORT];
    route_t            route_q  [NREQ];

    generate
        if (MODE == ARB_ROTATE) begin : g_rotate
            logic [PW-1:0]    ptr_q;
            logic [NREQ-1:0]  avail    [NPORT];
            logic [PW-1:0]    pick_idx [NPORT];
            logic [NPORT-1:0] pick_ok;
            logic [PW-1:0]    last_idx;

            assign avail[0] = req_en_i;

            // each port searches from the same pointer among what the
            // earlier ports left, giving the first two in rotation order
            for (genvar p = 0; p < NPORT; p++) begin : g_pick
                shmem_rr_pick #(.N(NREQ), .PW(PW)) u_pick (
                    .req_i   (avail[p]),
                    .ptr_i   (ptr_q),
                    .gnt_o   (gnt[p]),
                    .idx_o   (pick_idx[p]),
                    .found_o (pick_ok[p])
                );
                if (p + 1 < NPORT) begin : g_chain
                    assign avail[p+1] = avail[p] & ~gnt[p];
                end
            end

            // last granted in rotation order is the highest port that found one
            always_comb begin
                last_idx = pick_idx[0];
                for (int p = 1; p < NPORT; p++) begin
                    if (pick_ok[p]) last_idx = pick_idx[p];
                end
            end

            always_ff @(posedge clk) begin
                if (rst)           ptr_q <= '0;
                else if (|pick_ok) ptr_q <= PW'(wrap_inc(int'(last_idx), NREQ));
            end

            // R3: the two ports never serve the same requester
            assert_disjoint_R3: assert property (@(posedge clk) disable iff (rst)
                (gnt[0] & gnt[1]) == '0);

            if (NREQ <= 4) begin : g_bound
                for (genvar i = 0; i < NREQ; i++) begin : g_req
                    assert_next_cycle_R7: assert property (@(posedge clk) disable iff (rst)
                        req_stall_o[i] |=> (!req_en_i[i] || !req_stall_o[i]));
                end
            end
        end else begin : g_merge
            // requesters never overlap: everything merges onto port 0
            assign gnt[0] = req_en_i;
            for (genvar p = 1; p < NPORT; p++) begin : g_idle
                assign gnt[p] = '0;
            end
        end
    endgenerate

    generate
        for (genvar p = 0; p < NPORT; p++) begin : g_port
            shmem_port_mux #(.N(NREQ), .AW(ADDR_W), .DW(DATA_W)) u_mux (
                .gnt_i   (gnt[p]),
                .we_i    (req_we_i),
                .addr_i  (req_addr_i),
                .wdata_i (req_wdata_i),
                .en_o    (ram_en[p]),
                .we_o    (ram_we[p]),
                .addr_o  (ram_addr[p]),
                .wdata_o (ram_wd[p])
            );
        end
    endgenerate

    shmem_dpram #(.AW(ADDR_W), .DW(DATA_W)) u_ram (
        .clk     (clk),
        .a_en    (ram_en[0]),
        .a_we    (ram_we[0]),
        .a_addr  (ram_addr[0]),
        .a_wdata (ram_wd[0]),
        .a_rdata (ram_rd[0]),
        .b_en    (ram_en[1]),
        .b_we    (ram_we[1]),
        .b_addr  (ram_addr[1]),
        .b_wdata (ram_wd[1]),
        .b_rdata (ram_rd[1])
    );

    always_comb begin
        served = '0;
        for (int p = 0; p < NPORT; p++) served = served | gnt[p];
    end

    assign req_stall_o = req_en_i & ~served;

    // remember which granted reads to hand data back to next cycle
    always_ff @(posedge clk) begin
        for (int i = 0; i < NREQ; i++) begin
            if (rst) begin
                route_q[i] <= '0;
            end else begin
                route_q[i].hit  <= served[i] & ~req_we_i[i];
                route_q[i].port <= gnt[1][i];
            end
        end
    end

    always_comb begin
        for (int i = 0; i < NREQ; i++) begin
            if (!route_q[i].hit)     req_rdata_o[i*DATA_W +: DATA_W] = '0;
            else if (route_q[i].port) req_rdata_o[i*DATA_W +: DATA_W] = ram_rd[1];
            else                     req_rdata_o[i*DATA_W +: DATA_W] = ram_rd[0];
        end
    end

    assert_grant_limit_R2: assert property (@(posedge clk) disable iff (rst)
        $countones(req_en_i & ~req_stall_o) <= NPORT);

    assert_light_load_R2: assert property (@(posedge clk) disable iff (rst)
        ($countones(req_en_i) <= NPORT) |-> (req_stall_o == '0));

    generate
        for (genvar i = 0; i < NREQ; i++) begin : g_quiet
            assert_rdata_quiet_R6: assert property (@(posedge clk) disable iff (rst)
                !(req_en_i[i] && !req_stall_o[i] && !req_we_i[i])
                |=> (req_rdata_o[i*DATA_W +: DATA_W] == '0));
        end
    endgenerate
endmodule

// File: tb/shmem_arbiter_test.sv
module shmem_arbiter_test;
    timeunit 1ns;
    timeprecision 1ps;
    import shmem_pkg::*;

    localparam int N  = 4;
    localparam int AW = 6;
    localparam int DW = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // rotating-priority DUT stimulus
    logic [N-1:0]    en = '0;
    logic [N-1:0]    we = '0;
    logic [AW-1:0]   addr [N];
    logic [DW-1:0]   wd   [N];
    logic [N*AW-1:0] addr_f;
    logic [N*DW-1:0] wd_f;
    logic [N*DW-1:0] rd_f;
    logic [N-1:0]    stall;

    // merge-mode DUT stimulus
    logic [N-1:0]    o_en = '0;
    logic [N-1:0]    o_we = '0;
    logic [N*AW-1:0] o_addr_f = '0;
    logic [N*DW-1:0] o_wd_f = '0;
    logic [N*DW-1:0] o_rd;
    logic [N-1:0]    o_stall;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            addr_f[i*AW +: AW] = addr[i];
            wd_f[i*DW +: DW]   = wd[i];
        end
    end

    shmem_arbiter #(.NREQ(N), .ADDR_W(AW), .DATA_W(DW), .MODE(ARB_ROTATE)) uut (
        .clk(clk), .rst(rst), .req_en_i(en), .req_we_i(we),
        .req_addr_i(addr_f), .req_wdata_i(wd_f),
        .req_rdata_o(rd_f), .req_stall_o(stall)
    );

    shmem_arbiter #(.NREQ(N), .ADDR_W(AW), .DATA_W(DW), .MODE(ARB_MERGE)) uut_or (
        .clk(clk), .rst(rst), .req_en_i(o_en), .req_we_i(o_we),
        .req_addr_i(o_addr_f), .req_wdata_i(o_wd_f),
        .req_rdata_o(o_rd), .req_stall_o(o_stall)
    );

    // independent reference state
    int            mptr = 0;
    logic [DW-1:0] mmem [1 << AW];

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic set_port(input int i, input logic [AW-1:0] a, input logic [DW-1:0] d);
        addr[i] = a;
        wd[i]   = d;
    endtask

    // one cycle: drive, check stall in-cycle, check read data after the edge
    task automatic step(input logic [N-1:0] e, input logic [N-1:0] w, input string tag);
        logic [N-1:0]  g;
        logic [DW-1:0] exp_rd [N];
        int            cnt;
        int            last;
        en = e;
        we = w;
        #1;
        g = '0; cnt = 0; last = -1;
        for (int k = 0; k < N; k++) begin
            int i;
            i = (mptr + k) % N;
            if (e[i] && cnt < 2) begin
                g[i] = 1'b1; cnt++; last = i;
            end
        end
        for (int i = 0; i < N; i++) begin
            chk(stall[i] == (e[i] & ~g[i]), tag, $sformatf("stall[%0d]", i),
                DW'(stall[i]), DW'(e[i] & ~g[i]));
            exp_rd[i] = (g[i] && !w[i]) ? mmem[addr[i]] : '0;
        end
        for (int k = 0; k < N; k++) begin
            int i;
            i = (mptr + k) % N;
            if (g[i] && w[i]) mmem[addr[i]] = wd[i];
        end
        if (last >= 0) mptr = (last + 1) % N;
        @(posedge clk);
        #1;
        for (int i = 0; i < N; i++) begin
            chk(rd_f[i*DW +: DW] === exp_rd[i], tag, $sformatf("rdata[%0d]", i),
                rd_f[i*DW +: DW], exp_rd[i]);
        end
    endtask

    task automatic t_reset();
        for (int i = 0; i < N; i++) set_port(i, '0, '0);
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        @(posedge clk);
        #1;
        chk(rd_f == '0, "R1", "rdata after reset", rd_f[DW-1:0], '0);
        chk(stall == '0, "R1", "stall after reset", DW'(stall), '0);
        // first contended cycle: pointer at 0 grants 0 and 1
        for (int i = 0; i < N; i++) set_port(i, AW'(i), 32'hA000_0000 + DW'(i));
        step(4'b1111, 4'b1111, "R1");
    endtask

    task automatic t_hold_and_rotate();
        // stalled 2 and 3 keep their requests and get through now
        step(4'b1111, 4'b1111, "R7");
        chk(mptr == 0, "R3", "model pointer after full turn", DW'(mptr), 0);
    endtask

    task automatic t_write_read();
        set_port(1, 6'd2, '0);
        set_port(3, 6'd0, '0);
        step(4'b1010, 4'b0000, "R2");
        set_port(0, 6'd1, '0);
        set_port(2, 6'd3, '0);
        set_port(3, 6'd2, '0);
        step(4'b1101, 4'b0000, "R3");
        step(4'b1101, 4'b0000, "R7");
        step(4'b0000, 4'b0000, "R6");
    endtask

    task automatic t_stalled_write();
        // three writers to fresh addresses; the stalled one lands a cycle late
        set_port(0, 6'd30, 32'h3000_0000);
        set_port(1, 6'd31, 32'h3100_0001);
        set_port(2, 6'd32, 32'h3200_0002);
        step(4'b0111, 4'b0111, "R4");
        step(4'b0111, 4'b0111, "R5");
        set_port(3, 6'd32, '0);
        step(4'b1000, 4'b0000, "R5");
        set_port(0, 6'd30, '0);
        set_port(1, 6'd31, '0);
        step(4'b0011, 4'b0000, "R5");
    endtask

    task automatic t_collide();
        set_port(2, 6'd10, 32'hC0DE_0002);
        set_port(3, 6'd10, 32'hC0DE_0003);
        step(4'b1100, 4'b1100, "R9");
        set_port(0, 6'd10, '0);
        step(4'b0001, 4'b0000, "R9");
    endtask

    task automatic t_read_during_write();
        set_port(0, 6'd20, 32'h0000_1111);
        step(4'b0001, 4'b0001, "R5");
        set_port(0, 6'd20, 32'h0000_2222);
        set_port(1, 6'd20, '0);
        step(4'b0011, 4'b0001, "R10");
        step(4'b0010, 4'b0000, "R10");
    endtask

    task automatic or_step(input int idx, input logic w, input logic [AW-1:0] a,
                           input logic [DW-1:0] d, input logic [DW-1:0] exp);
        o_en = '0; o_we = '0; o_addr_f = '0; o_wd_f = '0;
        o_en[idx] = 1'b1;
        o_we[idx] = w;
        o_addr_f[idx*AW +: AW] = a;
        o_wd_f[idx*DW +: DW]   = d;
        #1;
        chk(o_stall == '0, "R8", "merge stall", DW'(o_stall), '0);
        @(posedge clk);
        #1;
        for (int i = 0; i < N; i++) begin
            logic [DW-1:0] e;
            e = (i == idx && !w) ? exp : '0;
            chk(o_rd[i*DW +: DW] === e, "R8", $sformatf("merge rdata[%0d]", i),
                o_rd[i*DW +: DW], e);
        end
        o_en = '0;
    endtask

    task automatic t_merge();
        or_step(2, 1'b1, 6'd7, 32'h7777_0007, '0);
        or_step(3, 1'b1, 6'd8, 32'h8888_0008, '0);
        or_step(1, 1'b0, 6'd7, '0, 32'h7777_0007);
        or_step(0, 1'b0, 6'd8, '0, 32'h8888_0008);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_hold_and_rotate();
        t_write_read();
        t_stalled_write();
        t_collide();
        t_read_during_write();
        t_merge();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule